// File: doc/BRIEF.md
# Lockable Reload Watchdog Timer

This block is a 24-bit down-counting watchdog. It advances on a slow tick enable, so a slow clock source can drive it without a second clock domain. Software arms it with a kick strobe, or an always-on input arms it at reset. After that, the count must be restored from the reload value often enough to keep it from reaching zero. When the count does reach zero, the block raises either a reset request or an interrupt request, as a response-select input chooses. A strobe also asks for a wake-up when the timeout happens while the system is stopped.

Software sees four byte addresses. Address 0 is the control/status location. Addresses 1, 2 and 3 are the reload bytes. A guarded write protocol protects the reload value and the stop-mode disable bit. Software must first write two key bytes to address 0, and then either the three reload bytes in strict upper, high, low order, or a single stop-mode setting byte. Any write that breaks this order closes the lock. Status flags record why the system last restarted, and reading them clears them.

Top module: `wdog_timer`

## Requirements
- R1: After reset, status address 0 reads 80h (power-on flag in bit 7, all other bits 0), the count equals the clamped reset reload value, and no request output is high.
- R2: A kick loads the count from the reload value. A reload value below 000004h is loaded as 000004h.
- R3: While armed, each tick lowers the count by one. The tick that takes the count from 1 to 0 makes exactly one of rst_req (resp_irq=0) or irq_req (resp_irq=1) high for one cycle. The two are never high together.
- R4: With resp_irq=1, the next tick after a timeout wraps the count to FFFFFFh and counting continues. With resp_irq=0, the count holds at 0.
- R5: A kick while the count is 000002h or lower has no effect. A kick at 000003h or above reloads the count.
- R6: The reload value changes only through this exact write sequence: 55h to address 0, AAh to address 0, then the byte for bits 23:16 to address 1, bits 15:8 to address 2, and bits 7:0 to address 3. All three bytes take effect together on the last write. Any other write inside the sequence returns the lock to idle and discards the staged bytes.
- R7: Right after the two keys, writing 81h to address 0 sets the stop-mode disable bit (status bit 0 and the stop_off output). Writing 00h there clears it. The same values have no effect without the keys.
- R8: Status bits are: bit 7 power-on, bit 6 stop recovery, bit 5 watchdog timeout, bit 4 external reset, bits 3:1 zero. A read of address 0 clears bits 7:4. Register writes, key writes included, never change bits 7:4.
- R9: A timeout or a stop-recovery strobe clears the power-on flag. A timeout while in_stop is high pulses wake_req and sets both the stop and timeout flags. ext_rst sets the external flag.
- R10: Reads of addresses 1, 2 and 3 return count bits 23:16, 15:8 and 7:0.
- R11: While debug_hold is high and the timer is armed, the count is reloaded every cycle, so ticks do not lower it.
- R12: always_on=1 during reset arms the timer at once. With always_on=0, ticks have no effect until the first kick. Once armed, the timer stays armed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| tick | input | 1 | Slow time-base enable, one count step per high cycle |
| kick | input | 1 | Arm or refresh strobe |
| debug_hold | input | 1 | Continuous refresh while high |
| resp_irq | input | 1 | Timeout response: 0 reset request, 1 interrupt request |
| always_on | input | 1 | Arm at reset without a kick |
| in_stop | input | 1 | System is in stop mode |
| stop_rec | input | 1 | Strobe: a stop-mode recovery took place |
| ext_rst | input | 1 | Strobe: an external reset was seen |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request on timeout |
| irq_req | output | 1 | One-cycle interrupt request on timeout |
| wake_req | output | 1 | One-cycle wake request on a timeout during stop |
| stop_off | output | 1 | Stop-mode disable setting |

## Verification
The assertions check these properties on every cycle:
- the timer never disarms;
- the reset and interrupt requests are never high together;
- a timeout pulse coincides with a zero count;
- a kick at or below the floor leaves the count alone;
- debug hold reloads the count;
- the reload value and the stop bit move only on the closing write of a correct sequence.

Only the bench scenarios can show the following:
- the timeout lands on the tick predicted from the clamped reload value;
- the wrap to FFFFFFh;
- the exact status byte after each restart cause;
- a broken sequence leaves the old reload value in force.

A sweep over small reload values covers the clamp boundary and the tick-by-tick count.

// File: rtl/wdog_pkg.sv
// Shared constants, types and helpers for the watchdog timer.
// Assumes a three-byte count and a four-location byte register space.
package wdog_pkg;
    localparam int CNT_W     = 24;
    localparam int BYTE_W    = 8;
    localparam int MIN_LOAD  = 4;
    localparam int KICK_FLOOR = 2;
    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;
    localparam logic [BYTE_W-1:0] STOP_SET   = 8'h81;
    localparam logic [BYTE_W-1:0] STOP_CLR   = 8'h00;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_UPPER = 2'd1,
        A_HIGH  = 2'd2,
        A_LOW   = 2'd3
    } addr_e;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_KEY1,
        LK_OPEN,
        LK_HAVE_U,
        LK_HAVE_H
    } lock_e;

    // Raise a reload value to the smallest legal load value.
    function automatic cnt_t clamp_load(input cnt_t v);
        return (v < cnt_t'(MIN_LOAD)) ? cnt_t'(MIN_LOAD) : v;
    endfunction
endpackage

// File: rtl/wdog_unlock.sv
// Key-guarded write path for the reload value and the stop-mode disable bit.
// Two key writes to the control address open the lock. After them, either one
// stop-setting byte or three ordered reload bytes are accepted. The staged bytes
// commit together on the final byte. Any out-of-order write returns to idle.
module wdog_unlock
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_INIT = 24'h000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output cnt_t              reload,
    output logic              stop_off
);
    lock_e             st;
    logic [BYTE_W-1:0] stg_u;
    logic [BYTE_W-1:0] stg_h;

    // Lock sequencer, staging bytes and committed settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LK_IDLE;
            stg_u    <= '0;
            stg_h    <= '0;
            reload   <= RELOAD_INIT;
            stop_off <= 1'b0;
        end else if (wr_en) begin
            st <= LK_IDLE;
            case (st)
                LK_IDLE: begin
                    if (addr == A_CTRL && wdata == KEY_FIRST) st <= LK_KEY1;
                end
                LK_KEY1: begin
                    if (addr == A_CTRL && wdata == KEY_SECOND) st <= LK_OPEN;
                end
                LK_OPEN: begin
                    if (addr == A_UPPER) begin
                        stg_u <= wdata;
                        st    <= LK_HAVE_U;
                    end else if (addr == A_CTRL && wdata == STOP_SET) begin
                        stop_off <= 1'b1;
                    end else if (addr == A_CTRL && wdata == STOP_CLR) begin
                        stop_off <= 1'b0;
                    end
                end
                LK_HAVE_U: begin
                    if (addr == A_HIGH) begin
                        stg_h <= wdata;
                        st    <= LK_HAVE_H;
                    end
                end
                LK_HAVE_H: begin
                    if (addr == A_LOW) reload <= {stg_u, stg_h, wdata};
                end
                default: st <= LK_IDLE;
            endcase
        end
    end

    // R6: the reload value moves only on the closing byte of a full sequence
    assert_reload_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reload) |-> $past(st == LK_HAVE_H && wr_en && addr == A_LOW));

    // R7: the stop bit moves only on a write right after the two keys
    assert_stop_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stop_off) |-> $past(st == LK_OPEN && wr_en && addr == A_CTRL));
endmodule

// File: rtl/wdog_count.sv
// Arming, refresh and down-count datapath of the watchdog.
// Assumes tick is a one-cycle enable from a slow time base. The reload input
// is clamped on every load. The timeout pulses are registered.
module wdog_count
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_INIT = 24'h000100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick,
    input  logic debug_hold,
    input  logic resp_irq,
    input  logic in_stop,
    input  logic always_on,
    input  cnt_t reload,
    output cnt_t cnt,
    output logic armed,
    output logic tmo_pulse,
    output logic rst_req,
    output logic irq_req,
    output logic wake_req
);
    logic above_floor;

    // Refresh is accepted only while the count is above the floor.
    always_comb above_floor = (cnt > cnt_t'(KICK_FLOOR));

    // Count register, arm state and timeout request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= always_on;
            cnt       <= clamp_load(RELOAD_INIT);
            tmo_pulse <= 1'b0;
            rst_req   <= 1'b0;
            irq_req   <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            tmo_pulse <= 1'b0;
            rst_req   <= 1'b0;
            irq_req   <= 1'b0;
            wake_req  <= 1'b0;
            if (!armed) begin
                if (kick) begin
                    armed <= 1'b1;
                    cnt   <= clamp_load(reload);
                end
            end else if (debug_hold || (kick && above_floor)) begin
                cnt <= clamp_load(reload);
            end else if (tick) begin
                if (cnt == cnt_t'(1)) begin
                    cnt       <= '0;
                    tmo_pulse <= 1'b1;
                    rst_req   <= !resp_irq;
                    irq_req   <= resp_irq;
                    wake_req  <= in_stop;
                end else if (cnt != '0 || resp_irq) begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R12: once armed, the timer stays armed
    assert_armed_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R3: only one response kind at a time
    assert_one_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq_req));

    // R3: a timeout pulse comes with a zero count
    assert_tmo_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> (cnt == '0));

    // R5: a kick at or below the floor leaves the count alone
    assert_kick_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && kick && !debug_hold && !tick && cnt <= cnt_t'(KICK_FLOOR)) |=> $stable(cnt));

    // R11: debug hold reloads the count
    assert_debug_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && debug_hold) |=> (cnt == clamp_load($past(reload))));
endmodule

// File: rtl/wdog_status.sv
// Restart-cause flags. Events set the flags and a status read clears them.
// A set wins over a clear in the same cycle, so no event is lost to a read.
module wdog_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmo_pulse,
    input  logic       wake_req,
    input  logic       stop_rec,
    input  logic       ext_rst,
    input  logic       rd_clr,
    output logic [3:0] flags
);
    logic f_por, f_stop, f_tmo, f_ext;

    // Flag update: set by event, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_por  <= 1'b1;
            f_stop <= 1'b0;
            f_tmo  <= 1'b0;
            f_ext  <= 1'b0;
        end else begin
            if (tmo_pulse || stop_rec || rd_clr) f_por <= 1'b0;
            if (wake_req || stop_rec)  f_stop <= 1'b1;
            else if (rd_clr)           f_stop <= 1'b0;
            if (tmo_pulse)             f_tmo  <= 1'b1;
            else if (rd_clr)           f_tmo  <= 1'b0;
            if (ext_rst)               f_ext  <= 1'b1;
            else if (rd_clr)           f_ext  <= 1'b0;
        end
    end

    always_comb flags = {f_por, f_stop, f_tmo, f_ext};

    // R9: a timeout or a stop recovery clears the power-on flag
    assert_por_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_pulse || stop_rec) |=> !f_por);

    // R9: a timeout is recorded even when a read happens in the same cycle
    assert_tmo_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> f_tmo);
endmodule

// File: rtl/wdog_timer.sv
// Top of the watchdog timer. It joins the lock path, the count datapath and
// the status flags, and decodes the byte read port.
// Assumes a single-cycle, non-overlapping read or write per bus cycle.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RELOAD_INIT = 24'h000100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic       debug_hold,
    input  logic       resp_irq,
    input  logic       always_on,
    input  logic       in_stop,
    input  logic       stop_rec,
    input  logic       ext_rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_req,
    output logic       irq_req,
    output logic       wake_req,
    output logic       stop_off
);
    cnt_t       reload;
    cnt_t       cnt;
    logic       armed;
    logic       tmo_pulse;
    logic [3:0] flags;
    logic       rd_clr;

    wdog_unlock #(.RELOAD_INIT(RELOAD_INIT)) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .reload(reload), .stop_off(stop_off)
    );

    wdog_count #(.RELOAD_INIT(RELOAD_INIT)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
        .debug_hold(debug_hold), .resp_irq(resp_irq), .in_stop(in_stop),
        .always_on(always_on), .reload(reload), .cnt(cnt), .armed(armed),
        .tmo_pulse(tmo_pulse), .rst_req(rst_req), .irq_req(irq_req),
        .wake_req(wake_req)
    );

    // Reading the status address clears the cause flags.
    always_comb rd_clr = rd_en && (addr == A_CTRL);

    wdog_status u_status (
        .clk(clk), .rst_n(rst_n), .tmo_pulse(tmo_pulse), .wake_req(wake_req),
        .stop_rec(stop_rec), .ext_rst(ext_rst), .rd_clr(rd_clr), .flags(flags)
    );

    // Read mux: status at address 0, count bytes at addresses 1 to 3.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {flags, 3'b000, stop_off};
            A_UPPER: rdata = cnt[23:16];
            A_HIGH:  rdata = cnt[15:8];
            default: rdata = cnt[7:0];
        endcase
    end

    // R12: an armed timer never reports disarmed through a request pair
    assert_req_needs_arm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq_req) |-> armed);
endmodule

// File: tb/sim_wdog_timer.sv
// Self-checking bench for the watchdog timer.
module sim_wdog_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, kick = 0, debug_hold = 0, resp_irq = 0, always_on = 1;
    logic       in_stop = 0, stop_rec = 0, ext_rst = 0, wr_en = 0, rd_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rst_req, irq_req, wake_req, stop_off;

    int errors = 0;
    int checks = 0;
    logic seen_rst, seen_irq, seen_wake;

    always #5 clk = ~clk;

    wdog_timer #(.RELOAD_INIT(24'h000100)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .debug_hold(debug_hold),
        .resp_irq(resp_irq), .always_on(always_on), .in_stop(in_stop),
        .stop_rec(stop_rec), .ext_rst(ext_rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req),
        .irq_req(irq_req), .wake_req(wake_req), .stop_off(stop_off)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic aon);
        always_on = aon;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic get_count(output logic [23:0] c);
        logic [7:0] b2, b1, b0;
        rd(2'd1, b2); rd(2'd2, b1); rd(2'd3, b0);
        c = {b2, b1, b0};
    endtask

    task automatic pulse_tick;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        seen_rst = rst_req; seen_irq = irq_req; seen_wake = wake_req;
        tick = 1'b0;
    endtask

    task automatic pulse_kick;
        @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    task automatic program_reload(input logic [23:0] v);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
        wr(2'd1, v[23:16]); wr(2'd2, v[15:8]); wr(2'd3, v[7:0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0]  v;
        logic [23:0] c;

        // R1 reset state
        do_reset(1'b1);
        check("R1 request outputs idle", {rst_req, irq_req, wake_req}, 0);
        get_count(c);
        check("R1 reset count", c, 24'h000100);
        rd(2'd0, v);
        check("R1 reset status", v, 8'h80);
        rd(2'd0, v);
        check("R8 status cleared by read", v, 8'h00);

        // R12 not armed without always_on until kicked
        do_reset(1'b0);
        repeat (3) pulse_tick;
        get_count(c);
        check("R12 unarmed ignores ticks", c, 24'h000100);
        pulse_kick;
        pulse_tick;
        get_count(c);
        check("R12 kick arms", c, 24'h0000FF);
        wr(2'd0, 8'h00);
        pulse_tick;
        get_count(c);
        check("R12 stays armed", c, 24'h0000FE);
        do_reset(1'b1);
        pulse_tick;
        get_count(c);
        check("R12 always-on arms at reset", c, 24'h0000FF);

        // R2 R3 R4 sweep of reload values in interrupt mode
        for (int r = 0; r <= 12; r++) begin
            int lv;
            lv = (r < 4) ? 4 : r;
            do_reset(1'b1);
            resp_irq = 1'b1;
            program_reload(24'(r));
            pulse_kick;
            get_count(c);
            check($sformatf("R2 clamped load r=%0d", r), c, 24'(lv));
            for (int k = 1; k <= lv; k++) begin
                pulse_tick;
                check($sformatf("R3 irq pulse r=%0d k=%0d", r, k), {seen_irq, seen_rst},
                      {(k == lv), 1'b0});
                get_count(c);
                check($sformatf("R3 count r=%0d k=%0d", r, k), c, 24'(lv - k));
            end
            pulse_tick;
            get_count(c);
            check($sformatf("R4 wrap r=%0d", r), c, 24'hFFFFFF);
        end
        pulse_tick;
        get_count(c);
        check("R4 continues after wrap", c, 24'hFFFFFE);

        // R10 byte positions, R6 abort paths
        do_reset(1'b1);
        resp_irq = 1'b0;
        program_reload(24'h012345);
        pulse_kick;
        get_count(c);
        check("R10 count byte order", c, 24'h012345);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd1, 8'h00);
        wr(2'd0, 8'h55); wr(2'd2, 8'h00); wr(2'd3, 8'h09);
        pulse_tick;
        pulse_kick;
        get_count(c);
        check("R6 interrupted sequence ignored", c, 24'h012345);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd2, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h09);
        pulse_tick;
        pulse_kick;
        get_count(c);
        check("R6 out-of-order bytes ignored", c, 24'h012345);
        wr(2'd0, 8'h55); wr(2'd1, 8'h00); wr(2'd0, 8'hAA);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h09);
        pulse_tick;
        pulse_kick;
        get_count(c);
        check("R6 broken key pair ignored", c, 24'h012345);

        // R5 refresh floor
        program_reload(24'd10);
        pulse_kick;
        repeat (7) pulse_tick;
        pulse_kick;
        get_count(c);
        check("R5 kick accepted at 3", c, 24'd10);
        repeat (8) pulse_tick;
        pulse_kick;
        get_count(c);
        check("R5 kick ignored at 2", c, 24'd2);
        pulse_tick;
        pulse_kick;
        get_count(c);
        check("R5 kick ignored at 1", c, 24'd1);

        // R3 R4 reset-style timeout holds at zero; R9 power-on cleared
        do_reset(1'b1);
        resp_irq = 1'b0;
        program_reload(24'd5);
        pulse_kick;
        repeat (4) pulse_tick;
        pulse_tick;
        check("R3 reset request pulse", {seen_rst, seen_irq, seen_wake}, 3'b100);
        pulse_tick;
        get_count(c);
        check("R4 reset mode holds zero", c, 24'd0);
        rd(2'd0, v);
        check("R9 timeout clears power-on", v, 8'h20);

        // R9 timeout during stop
        do_reset(1'b1);
        in_stop = 1'b1;
        program_reload(24'd4);
        pulse_kick;
        repeat (3) pulse_tick;
        pulse_tick;
        check("R9 wake on stop timeout", seen_wake, 1'b1);
        in_stop = 1'b0;
        rd(2'd0, v);
        check("R9 stop and timeout flags", v, 8'h60);

        // R9 stop recovery strobe
        do_reset(1'b1);
        @(negedge clk); stop_rec = 1'b1;
        @(negedge clk); stop_rec = 1'b0;
        rd(2'd0, v);
        check("R9 stop recovery flag", v, 8'h40);

        // R7 R8 stop bit and key writes leave status alone
        @(negedge clk); ext_rst = 1'b1;
        @(negedge clk); ext_rst = 1'b0;
        wr(2'd0, 8'h81);
        check("R7 stop bit needs keys", stop_off, 1'b0);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h81);
        check("R7 stop bit set", stop_off, 1'b1);
        rd(2'd0, v);
        check("R8 ext flag kept through key writes", v, 8'h11);
        wr(2'd0, 8'h55); wr(2'd0, 8'hAA); wr(2'd0, 8'h00);
        rd(2'd0, v);
        check("R7 stop bit cleared", v, 8'h00);

        // R11 debug hold
        program_reload(24'd6);
        @(negedge clk); debug_hold = 1'b1;
        repeat (3) pulse_tick;
        get_count(c);
        check("R11 debug hold keeps reload", c, 24'd6);
        @(negedge clk); debug_hold = 1'b0;
        pulse_tick;
        get_count(c);
        check("R11 counting resumes", c, 24'd5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule